// File: doc/BRIEF.md
# Transmit Command and Queue Handler

This block sits on the transmit side of a cell segmentation unit. It takes host commands over a valid/ready channel and handles one command at a time. Each command ends with exactly one indication carrying an error flag and a data word. An open command takes a 16-word per-channel table block from a fixed pool and returns the block's word address. A close command gives a block back to the pool. A transmit-ready command carries a channel number and a descriptor word. The block copies both into a packet-info record and links that record onto a transmit queue.

The queue is a singly linked list held in a small internal record store, with head and tail pointers. When a transmit-ready command finds the queue empty, the block arms the cell scheduler for the current time plus one. When the queue already holds work, the new record is only appended at the tail. The cell engine reads the head record from dedicated outputs and removes it with a pop strobe when that packet is done. A pop may arrive in the same cycle as an append.

Top module: `tx_cmd_queue`

## Requirements
- R1: After reset `cmdReady` is 1, `indValid`, `schedValid` and `headValid` are 0, and all pool blocks and records are free.
- R2: Command code 0 (open) with a free block returns `indErr`=0 and `indData` = POOL_BASE + 16·k, where k is the lowest free block index. That block then stays allocated.
- R3: Open with no free block returns `indErr`=1 and allocates nothing, so a later close followed by open hands back exactly the closed block.
- R4: Command code 1 (close) with `cmdArg` equal to the address of an allocated block frees it and returns `indErr`=0. Any other address is rejected with `indErr`=1 and leaves the pool unchanged: below the base, not a multiple of 16 above it, beyond the last block, or an already free block.
- R5: Command code 2 (transmit-ready) with a free record stores `cmdArg` low bits as the channel and `cmdDesc` as the descriptor in the lowest free record. It returns that record index in `indData`, and records leave the queue in arrival order through `headIdx`/`headVc`/`headDesc`.
- R6: A transmit-ready that finds the queue empty, after any pop in the same cycle, pulses `schedValid` during its indication cycle with `schedTime` = `curTime` + 1, where `curTime` is sampled in the cycle before the indication. A transmit-ready that finds the queue non-empty does not pulse `schedValid`.
- R7: `popReq` with `headValid`=1 removes the head record and leaves the rest in order. `popReq` on an empty queue has no effect. The head does not change without a pop, except when the first record enters an empty queue.
- R8: A transmit-ready and a pop in the same cycle on a one-entry queue leave the queue holding exactly the new record.
- R9: `cmdReady` falls after each accepted command. `indValid` is high for exactly the one cycle that starts two clock edges after the accept edge, and `cmdReady` returns high on the next edge.
- R10: Transmit-ready with no free record, and command code 3, return `indErr`=1 and change neither the queue nor the pool.
- R11: A record freed by a pop becomes available to the next transmit-ready as a candidate for the lowest free index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Handler idle and able to accept a command |
| cmdOp | input | 2 | 0 open, 1 close, 2 transmit-ready, 3 reserved |
| cmdArg | input | ADDR_W | Block address (close) or channel number in the low VC_W bits (transmit-ready) |
| cmdDesc | input | DESC_W | Descriptor word for transmit-ready |
| curTime | input | TIME_W | Current scheduler time |
| indValid | output | 1 | One-cycle indication for the finished command |
| indErr | output | 1 | Command failed |
| indData | output | ADDR_W | Block address, record index, or echoed close address |
| schedValid | output | 1 | Scheduler arm request |
| schedTime | output | TIME_W | Slot requested from the scheduler |
| popReq | input | 1 | Cell engine removes the head record |
| headValid | output | 1 | Queue non-empty |
| headIdx | output | REC_W | Head record index |
| headVc | output | VC_W | Channel number of the head record |
| headDesc | output | DESC_W | Descriptor of the head record |

## Verification
The bound checker watches the handshake cadence on every cycle. It checks that ready drops after an accept, that each indication is a single cycle placed two edges after its accept, and that an arm request only rides a successful indication with a time one past the sampled clock. It also checks that the head stays put without a pop. The arithmetic of block addresses, lowest-free selection, FIFO order across pops and appends, and the empty-versus-non-empty arming decision, including the same-cycle pop and append, can only be shown by the bench. The bench runs its scenarios against a reference model of the pool and queue.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    OP_OPEN  = 2'd0,
    OP_CLOSE = 2'd1,
    OP_TXRDY = 2'd2,
    OP_RSVD  = 2'd3
  } cmdOp_e;

  typedef struct packed {
    logic doOpen;
    logic doClose;
    logic doAppend;
  } strobes_t;
endpackage

// File: rtl/txq_alloc.sv
module txq_alloc #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          allocEn,
  input  logic          freeEn,
  input  logic [IW-1:0] freeIdx,
  output logic          anyFree,
  output logic [IW-1:0] lowIdx,
  output logic [N-1:0]  freeMask
);
  always_comb begin
    lowIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (freeMask[i]) lowIdx = IW'(i);
    end
  end

  assign anyFree = |freeMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freeMask <= '1;
    end else begin
      if (allocEn) freeMask[lowIdx] <= 1'b0;
      if (freeEn)  freeMask[freeIdx] <= 1'b1;
    end
  end
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DESC_W = 32,
  parameter int TIME_W = 16,
  parameter int REC_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdArg,
  input  logic [DESC_W-1:0] cmdDesc,
  input  logic [TIME_W-1:0] curTime,
  input  logic              blkAvail,
  input  logic [ADDR_W-1:0] blkAddr,
  input  logic              closeOk,
  input  logic              recAvail,
  input  logic [REC_W-1:0]  recIdx,
  input  logic              emptyAfterPop,
  output strobes_t          stb,
  output logic [ADDR_W-1:0] argQ,
  output logic [DESC_W-1:0] descQ,
  output logic              indValid,
  output logic              indErr,
  output logic [ADDR_W-1:0] indData,
  output logic              schedValid,
  output logic [TIME_W-1:0] schedTime
);
  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_IND} state_e;
  state_e state;
  cmdOp_e opQ;

  assign cmdReady = (state == S_IDLE);

  always_comb begin
    stb = '0;
    if (state == S_EXEC) begin
      case (opQ)
        OP_OPEN:  stb.doOpen   = blkAvail;
        OP_CLOSE: stb.doClose  = closeOk;
        OP_TXRDY: stb.doAppend = recAvail;
        default:  stb = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      opQ        <= OP_OPEN;
      argQ       <= '0;
      descQ      <= '0;
      indValid   <= 1'b0;
      indErr     <= 1'b0;
      indData    <= '0;
      schedValid <= 1'b0;
      schedTime  <= '0;
    end else begin
      indValid   <= 1'b0;
      schedValid <= 1'b0;
      case (state)
        S_IDLE: if (cmdValid) begin
          opQ   <= cmdOp_e'(cmdOp);
          argQ  <= cmdArg;
          descQ <= cmdDesc;
          state <= S_EXEC;
        end
        S_EXEC: begin
          indValid <= 1'b1;
          state    <= S_IND;
          case (opQ)
            OP_OPEN: begin
              indErr  <= !blkAvail;
              indData <= blkAvail ? blkAddr : '0;
            end
            OP_CLOSE: begin
              indErr  <= !closeOk;
              indData <= argQ;
            end
            OP_TXRDY: begin
              indErr     <= !recAvail;
              indData    <= {{(ADDR_W - REC_W){1'b0}}, recIdx};
              schedValid <= recAvail && emptyAfterPop;
              schedTime  <= curTime + TIME_W'(1);
            end
            default: begin
              indErr  <= 1'b1;
              indData <= '0;
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txq_data.sv
module txq_data
  import txq_pkg::*;
#(
  parameter int NUM_BLOCKS  = 8,
  parameter int BLOCK_WORDS = 16,
  parameter int POOL_BASE   = 'h400,
  parameter int ADDR_W      = 16,
  parameter int NUM_RECS    = 8,
  parameter int VC_W        = 8,
  parameter int DESC_W      = 32,
  localparam int BLK_IW = $clog2(NUM_BLOCKS),
  localparam int REC_W  = $clog2(NUM_RECS),
  localparam int BLK_SH = $clog2(BLOCK_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [ADDR_W-1:0] argQ,
  input  logic [DESC_W-1:0] descQ,
  input  logic              popReq,
  output logic              blkAvail,
  output logic [ADDR_W-1:0] blkAddr,
  output logic              closeOk,
  output logic              recAvail,
  output logic [REC_W-1:0]  recIdx,
  output logic              emptyAfterPop,
  output logic              headValid,
  output logic [REC_W-1:0]  headIdx,
  output logic [VC_W-1:0]   headVc,
  output logic [DESC_W-1:0] headDesc
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(POOL_BASE);
  localparam logic [ADDR_W-1:0] NBLK = ADDR_W'(NUM_BLOCKS);

  logic [BLK_IW-1:0]     blkLow, closeIdx;
  logic [NUM_BLOCKS-1:0] blkFree;
  logic [NUM_RECS-1:0]   recFree;
  logic [ADDR_W-1:0]     offset;
  logic                  addrOk;

  // channel-table block pool
  txq_alloc #(.N(NUM_BLOCKS)) uBlk (
    .clk(clk), .rstN(rstN), .allocEn(stb.doOpen), .freeEn(stb.doClose),
    .freeIdx(closeIdx), .anyFree(blkAvail), .lowIdx(blkLow), .freeMask(blkFree)
  );

  assign blkAddr  = BASE + (ADDR_W'(blkLow) << BLK_SH);
  assign offset   = argQ - BASE;
  assign closeIdx = offset[BLK_SH +: BLK_IW];
  assign addrOk   = (argQ >= BASE) && (offset[BLK_SH-1:0] == '0) &&
                    ((offset >> BLK_SH) < NBLK);
  assign closeOk  = addrOk && !blkFree[closeIdx];

  // packet-info records and queue linkage
  logic [REC_W-1:0]  recNext [NUM_RECS];
  logic [VC_W-1:0]   recVc   [NUM_RECS];
  logic [DESC_W-1:0] recDesc [NUM_RECS];
  logic [REC_W-1:0]  tailIdx;
  logic              qEmpty, popEff, lastOne;

  assign popEff        = popReq && !qEmpty;
  assign lastOne       = (headIdx == tailIdx);
  assign emptyAfterPop = qEmpty || (popEff && lastOne);
  assign headValid     = !qEmpty;
  assign headVc        = recVc[headIdx];
  assign headDesc      = recDesc[headIdx];

  txq_alloc #(.N(NUM_RECS)) uRec (
    .clk(clk), .rstN(rstN), .allocEn(stb.doAppend), .freeEn(popEff),
    .freeIdx(headIdx), .anyFree(recAvail), .lowIdx(recIdx), .freeMask(recFree)
  );

  always_ff @(posedge clk) begin
    if (stb.doAppend) begin
      recVc[recIdx]   <= argQ[VC_W-1:0];
      recDesc[recIdx] <= descQ;
      if (!emptyAfterPop) recNext[tailIdx] <= recIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qEmpty  <= 1'b1;
      headIdx <= '0;
      tailIdx <= '0;
    end else if (stb.doAppend) begin
      tailIdx <= recIdx;
      qEmpty  <= 1'b0;
      if (emptyAfterPop)  headIdx <= recIdx;
      else if (popEff)    headIdx <= recNext[headIdx];
    end else if (popEff) begin
      if (lastOne) qEmpty <= 1'b1;
      else         headIdx <= recNext[headIdx];
    end
  end
endmodule

// File: rtl/tx_cmd_queue.sv
module tx_cmd_queue
  import txq_pkg::*;
#(
  parameter int NUM_BLOCKS  = 8,
  parameter int BLOCK_WORDS = 16,
  parameter int POOL_BASE   = 'h400,
  parameter int ADDR_W      = 16,
  parameter int NUM_RECS    = 8,
  parameter int VC_W        = 8,
  parameter int DESC_W      = 32,
  parameter int TIME_W      = 16,
  localparam int REC_W = $clog2(NUM_RECS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdArg,
  input  logic [DESC_W-1:0] cmdDesc,
  input  logic [TIME_W-1:0] curTime,
  output logic              indValid,
  output logic              indErr,
  output logic [ADDR_W-1:0] indData,
  output logic              schedValid,
  output logic [TIME_W-1:0] schedTime,
  input  logic              popReq,
  output logic              headValid,
  output logic [REC_W-1:0]  headIdx,
  output logic [VC_W-1:0]   headVc,
  output logic [DESC_W-1:0] headDesc
);
  strobes_t          stb;
  logic [ADDR_W-1:0] argQ, blkAddr;
  logic [DESC_W-1:0] descQ;
  logic              blkAvail, closeOk, recAvail, emptyAfterPop;
  logic [REC_W-1:0]  recIdx;

  txq_ctrl #(.ADDR_W(ADDR_W), .DESC_W(DESC_W), .TIME_W(TIME_W), .REC_W(REC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdArg(cmdArg), .cmdDesc(cmdDesc), .curTime(curTime), .blkAvail(blkAvail),
    .blkAddr(blkAddr), .closeOk(closeOk), .recAvail(recAvail), .recIdx(recIdx),
    .emptyAfterPop(emptyAfterPop), .stb(stb), .argQ(argQ), .descQ(descQ),
    .indValid(indValid), .indErr(indErr), .indData(indData),
    .schedValid(schedValid), .schedTime(schedTime)
  );

  txq_data #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_WORDS(BLOCK_WORDS), .POOL_BASE(POOL_BASE),
             .ADDR_W(ADDR_W), .NUM_RECS(NUM_RECS), .VC_W(VC_W), .DESC_W(DESC_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .argQ(argQ), .descQ(descQ), .popReq(popReq),
    .blkAvail(blkAvail), .blkAddr(blkAddr), .closeOk(closeOk), .recAvail(recAvail),
    .recIdx(recIdx), .emptyAfterPop(emptyAfterPop), .headValid(headValid),
    .headIdx(headIdx), .headVc(headVc), .headDesc(headDesc)
  );
endmodule

// File: rtl/txq_checker.sv
module txq_checker #(
  parameter int TIME_W = 16,
  parameter int REC_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic              indValid,
  input logic              indErr,
  input logic              schedValid,
  input logic [TIME_W-1:0] schedTime,
  input logic [TIME_W-1:0] curTime,
  input logic              popReq,
  input logic              headValid,
  input logic [REC_W-1:0]  headIdx
);
  assert_ready_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  assert_ind_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    indValid |=> !indValid);

  assert_ind_placed_R9: assert property (@(posedge clk) disable iff (!rstN)
    indValid |-> $past(cmdValid && cmdReady, 2));

  assert_sched_with_ok_R6: assert property (@(posedge clk) disable iff (!rstN)
    schedValid |-> (indValid && !indErr));

  assert_sched_time_R6: assert property (@(posedge clk) disable iff (!rstN)
    schedValid |-> (schedTime == $past(curTime) + TIME_W'(1)));

  assert_head_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (headValid && !popReq) |=> (headValid && $stable(headIdx)));
endmodule

bind tx_cmd_queue txq_checker #(.TIME_W(TIME_W), .REC_W(REC_W)) uChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .indValid(indValid), .indErr(indErr), .schedValid(schedValid),
  .schedTime(schedTime), .curTime(curTime), .popReq(popReq),
  .headValid(headValid), .headIdx(headIdx)
);

// File: tb/tb_tx_cmd_queue.sv
module tb_tx_cmd_queue;
  localparam int NB = 8, NR = 8, BASE = 'h400;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        cmdValid = 1'b0, popReq = 1'b0;
  logic [1:0]  cmdOp = '0;
  logic [15:0] cmdArg = '0, curTime = '0;
  logic [31:0] cmdDesc = '0;
  logic        cmdReady, indValid, indErr, schedValid, headValid;
  logic [15:0] indData, schedTime;
  logic [2:0]  headIdx;
  logic [7:0]  headVc;
  logic [31:0] headDesc;

  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  bit blkUsed[NB];
  bit recUsed[NR];
  int qRec[NR];
  int qLen = 0;
  logic [7:0]  mVc[NR];
  logic [31:0] mDesc[NR];

  logic        gValid, gErr, gSched, gRdyExec, gRdyInd, gIndExec;
  logic [15:0] gData, gTime;

  always #10 clk = ~clk;

  tx_cmd_queue dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdArg(cmdArg), .cmdDesc(cmdDesc), .curTime(curTime), .indValid(indValid),
    .indErr(indErr), .indData(indData), .schedValid(schedValid), .schedTime(schedTime),
    .popReq(popReq), .headValid(headValid), .headIdx(headIdx), .headVc(headVc),
    .headDesc(headDesc)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lowFree(input bit used[], input int n);
    for (int i = 0; i < n; i++) if (!used[i]) return i;
    return -1;
  endfunction

  // drive one command; optionally pop during its execute cycle
  task automatic doCmd(input logic [1:0] op, input logic [15:0] arg,
                       input logic [31:0] desc, input bit pop);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdArg = arg; cmdDesc = desc;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0; popReq = pop;
    gRdyExec = cmdReady; gIndExec = indValid;
    @(posedge clk);
    @(negedge clk);
    popReq = 1'b0;
    gValid = indValid; gErr = indErr; gData = indData;
    gSched = schedValid; gTime = schedTime; gRdyInd = cmdReady;
    @(posedge clk);
    chk(!gRdyExec && !gIndExec && gValid && !gRdyInd, "R9 handshake", gValid, 1);
  endtask

  task automatic openT();
    int k;
    k = lowFree(blkUsed, NB);
    doCmd(2'd0, 16'h0, 32'h0, 1'b0);
    if (k >= 0) begin
      chk(!gErr, "R2 open err", gErr, 0);
      chk(gData == 16'(BASE + 16 * k), "R2 open addr", gData, BASE + 16 * k);
      blkUsed[k] = 1'b1;
    end else begin
      chk(gErr, "R3 open exhausted", gErr, 1);
    end
  endtask

  task automatic closeT(input int addr);
    bit ok;
    int off;
    off = addr - BASE;
    ok = (addr >= BASE) && (off % 16 == 0) && (off / 16 < NB) && blkUsed[off / 16];
    doCmd(2'd1, 16'(addr), 32'h0, 1'b0);
    chk(gErr == !ok, "R4 close", gErr, !ok);
    if (ok) blkUsed[off / 16] = 1'b0;
  endtask

  task automatic txT(input logic [7:0] vc, input logic [31:0] desc, input bit pop,
                     input logic [15:0] t);
    int k;
    bit emptyAfter;
    k = lowFree(recUsed, NR);
    curTime = t;
    doCmd(2'd2, {8'h0, vc}, desc, pop);
    if (pop && qLen > 0) begin
      recUsed[qRec[0]] = 1'b0;
      for (int i = 0; i < qLen - 1; i++) qRec[i] = qRec[i + 1];
      qLen--;
    end
    emptyAfter = (qLen == 0);
    if (k >= 0) begin
      chk(!gErr && gData == 16'(k), "R5 txready record", gData, k);
      chk(gSched == emptyAfter, "R6 arm decision", gSched, emptyAfter);
      if (emptyAfter) chk(gTime == t + 16'd1, "R6 sched time", gTime, t + 16'd1);
      recUsed[k] = 1'b1; mVc[k] = vc; mDesc[k] = desc;
      qRec[qLen] = k; qLen++;
    end else begin
      chk(gErr && !gSched, "R10 no record", gErr, 1);
    end
  endtask

  task automatic popT();
    @(negedge clk);
    popReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    popReq = 1'b0;
    if (qLen > 0) begin
      recUsed[qRec[0]] = 1'b0;
      for (int i = 0; i < qLen - 1; i++) qRec[i] = qRec[i + 1];
      qLen--;
    end
  endtask

  task automatic headT(input string req);
    @(negedge clk);
    if (qLen > 0)
      chk(headValid && headIdx == 3'(qRec[0]) && headVc == mVc[qRec[0]] &&
          headDesc == mDesc[qRec[0]], req, headIdx, qRec[0]);
    else
      chk(!headValid, req, headValid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmdReady && !indValid && !schedValid && !headValid, "R1 reset", cmdReady, 1);
    rstN = 1'b1;
    @(negedge clk);
    chk(cmdReady && !indValid && !headValid, "R1 after release", cmdReady, 1);

    // pool sweep: fill, overfill, frees in mixed order, bad addresses
    for (int i = 0; i < NB + 2; i++) openT();
    closeT(BASE - 16);
    closeT(BASE + 8);
    closeT(BASE + 16 * NB);
    closeT(BASE + 16 * 5);
    closeT(BASE + 16 * 5);
    closeT(BASE + 16 * 2);
    openT();
    openT();
    openT();
    for (int i = 0; i < NB; i++) closeT(BASE + 16 * ((i * 3) % NB));
    for (int i = 0; i < NB; i++) closeT(BASE + 16 * i);
    // reserved opcode leaves pool untouched
    doCmd(2'd3, 16'h0, 32'h0, 1'b0);
    chk(gErr, "R10 reserved op", gErr, 1);
    openT();
    openT();

    // queue: fill, overfill, FIFO drain
    headT("R7 empty head");
    for (int i = 0; i < NR + 1; i++)
      txT(8'(16 + i), 32'hA000_0000 + 32'(i * 7), 1'b0, 16'(100 * i + 3));
    headT("R5 head after fill");
    for (int i = 0; i < 3; i++) begin
      popT();
      headT("R7 head after pop");
    end
    txT(8'h55, 32'hBEEF_0001, 1'b0, 16'h0010);
    txT(8'h56, 32'hBEEF_0002, 1'b0, 16'h0011);
    chk(gData == 16'd1, "R11 reuse freed record", gData, 1);
    while (qLen > 0) begin
      popT();
      headT("R5 drain order");
    end
    popT();
    popT();
    headT("R7 pop on empty");

    // same-cycle pop and append
    txT(8'h01, 32'h1111_0000, 1'b1, 16'hFFFF);
    headT("R8 pop on empty with append");
    txT(8'h02, 32'h2222_0000, 1'b1, 16'h0200);
    headT("R8 one entry pop plus append");
    chk(qLen == 1 && headValid, "R8 single entry", qLen, 1);
    popT();
    headT("R8 queue empties");
    txT(8'h03, 32'h3333_0000, 1'b0, 16'h0300);
    txT(8'h04, 32'h4444_0000, 1'b0, 16'h0301);
    txT(8'h05, 32'h5555_0000, 1'b1, 16'h0302);
    headT("R7 pop plus append deeper");
    while (qLen > 0) begin
      popT();
      headT("R7 final drain");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule